// File: doc/BRIEF.md
# Privileged Register Access Checker

This block sits beside the load/store path and judges accesses aimed at the processor's internal register spaces. An address space identifier has already been decoded into one of three kinds: scratch registers, interrupt-queue registers or error-reporting registers. The block looks at the kind, the byte offset inside the space, the read/write direction and the current privileged and hyperprivileged mode bits. It then decides whether the access may go ahead, must trap as a data-access exception, or must trap as a privileged-action fault.

Each verdict comes out one clock after the request and lasts for one cycle. Every fault also raises a one-cycle request to write the fault-status register. That request carries an illegal-identifier reason, the primary context, a side-effect flag, the offending offset and the direction. The register storage and the fault-status register itself live elsewhere.

Top module: `preg_access_check`

## Requirements
- R1: While reset is low and in the first cycle after it, every output is 0.
- R2: A request in one cycle produces rsp_valid in the next cycle, with exactly one of rsp_allow, rsp_dax and rsp_priv_act high. A cycle without a request produces all-zero outputs one cycle later.
- R3: Scratch space (req_space 2'b00) at an offset above 0x38 gets rsp_dax, whatever the mode.
- R4: Scratch offsets 0x20 through 0x2F get rsp_dax unless mode_hpriv is set. All other scratch offsets up to 0x38 are allowed in any mode.
- R5: Queue space (req_space 2'b01) with both mode bits clear gets rsp_priv_act, whatever the offset.
- R6: A queue access in privileged or hyperprivileged mode whose offset is below 0x3C0 or above 0x3F8 gets rsp_dax.
- R7: A queue access inside the window with any of offset bits [3:0] set gets rsp_dax when mode_hpriv is clear and is allowed when mode_hpriv is set.
- R8: Error space (req_space 2'b10) is allowed when mode_hpriv is set. With only mode_priv set it gets rsp_dax, and with neither bit set it gets rsp_priv_act.
- R9: The unused space code 2'b11 always gets rsp_dax.
- R10: In the same cycle as any rsp_dax or rsp_priv_act, fsr_we is 1 and the record fields are set. fsr_reason is 3'b101 (illegal identifier), fsr_ctx is 2'b00 (primary), fsr_side_eff is 1, fsr_offset is the request offset and fsr_write is the request direction. On an allowed or empty cycle, fsr_we and every record field are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_space | input | 2 | Register space kind: 00 scratch, 01 queue, 10 error, 11 unused |
| req_offset | input | OFF_W | Byte offset within the space |
| req_write | input | 1 | 1 for a store, 0 for a load |
| mode_priv | input | 1 | Privileged mode |
| mode_hpriv | input | 1 | Hyperprivileged mode |
| rsp_valid | output | 1 | Verdict present |
| rsp_allow | output | 1 | Access permitted |
| rsp_dax | output | 1 | Data-access exception |
| rsp_priv_act | output | 1 | Privileged-action fault |
| fsr_we | output | 1 | Fault-status record write request |
| fsr_reason | output | 3 | Fault reason code |
| fsr_ctx | output | 2 | Context recorded with the fault |
| fsr_side_eff | output | 1 | Side-effect flag of the fault record |
| fsr_offset | output | OFF_W | Faulting offset |
| fsr_write | output | 1 | Faulting direction |

## Verification
A verdict register that is wrong appears on the response lines in the very next cycle. There is no hidden state that carries over to later requests, so each mistake shows up on exactly one response. Rule faults are boundary faults, such as an off-by-one at 0x38, 0x2F, 0x3C0 or 0x3F8, or an alignment test applied in the wrong mode. They show up only when the bench probes an offset on each side of each edge under each mode combination. A record that is not latched together with the fault shows up as a fault cycle with fsr_we low, or as a stale offset on the next cycle.

// File: rtl/pac_pkg.sv
package pac_pkg;

  typedef enum logic [1:0] {
    SP_SCRATCH = 2'b00,
    SP_QUEUE   = 2'b01,
    SP_ERROR   = 2'b10,
    SP_UNUSED  = 2'b11
  } space_e;

  typedef enum logic [1:0] {
    VD_ALLOW = 2'd0,
    VD_DAX   = 2'd1,
    VD_PACT  = 2'd2
  } verdict_e;

  localparam logic [2:0] REASON_ILLEGAL_ID = 3'b101;
  localparam logic [1:0] CTX_PRIMARY       = 2'b00;

  // inclusive window test
  function automatic logic in_window(input logic [31:0] off,
                                     input logic [31:0] lo,
                                     input logic [31:0] hi);
    return (off >= lo) && (off <= hi);
  endfunction

  // any of the low nbits set
  function automatic logic low_bits_set(input logic [31:0] off,
                                        input int unsigned nbits);
    logic [31:0] mask;
    mask = (32'd1 << nbits) - 32'd1;
    return (off & mask) != 32'd0;
  endfunction

endpackage

// File: rtl/pac_scratch_rule.sv
module pac_scratch_rule
  import pac_pkg::*;
#(
  parameter logic [31:0] SCR_TOP   = 32'h38,
  parameter logic [31:0] SCR_HP_LO = 32'h20,
  parameter logic [31:0] SCR_HP_HI = 32'h2F
) (
  input  logic [31:0] off,
  input  logic        hpriv,
  output verdict_e    vd,
  output logic        beyond_top,
  output logic        hp_window
);
  assign beyond_top = off > SCR_TOP;
  assign hp_window  = in_window(off, SCR_HP_LO, SCR_HP_HI);

  always_comb begin
    if (beyond_top || (hp_window && !hpriv)) vd = VD_DAX;
    else                                     vd = VD_ALLOW;
  end
endmodule

// File: rtl/pac_queue_rule.sv
module pac_queue_rule
  import pac_pkg::*;
#(
  parameter logic [31:0] Q_LO      = 32'h3C0,
  parameter logic [31:0] Q_HI      = 32'h3F8,
  parameter int unsigned ALIGN_LOG = 4
) (
  input  logic [31:0] off,
  input  logic        priv,
  input  logic        hpriv,
  output verdict_e    vd,
  output logic        no_mode,
  output logic        outside,
  output logic        misalign
);
  assign no_mode  = !priv && !hpriv;
  assign outside  = !in_window(off, Q_LO, Q_HI);
  assign misalign = low_bits_set(off, ALIGN_LOG);

  always_comb begin
    if (no_mode)                         vd = VD_PACT;
    else if (outside)                    vd = VD_DAX;
    else if (misalign && !hpriv)         vd = VD_DAX;
    else                                 vd = VD_ALLOW;
  end
endmodule

// File: rtl/pac_error_rule.sv
module pac_error_rule
  import pac_pkg::*;
(
  input  logic     priv,
  input  logic     hpriv,
  output verdict_e vd
);
  always_comb begin
    if (hpriv)     vd = VD_ALLOW;
    else if (priv) vd = VD_DAX;
    else           vd = VD_PACT;
  end
endmodule

// File: rtl/pac_resp_reg.sv
module pac_resp_reg
  import pac_pkg::*;
#(
  parameter int OFF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vin,
  input  verdict_e         vd,
  input  logic [OFF_W-1:0] off,
  input  logic             wr,
  output logic             rsp_valid,
  output logic             rsp_allow,
  output logic             rsp_dax,
  output logic             rsp_priv_act,
  output logic             fsr_we,
  output logic [2:0]       fsr_reason,
  output logic [1:0]       fsr_ctx,
  output logic             fsr_side_eff,
  output logic [OFF_W-1:0] fsr_offset,
  output logic             fsr_write
);
  logic fault;
  assign fault = vin && (vd != VD_ALLOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_allow    <= 1'b0;
      rsp_dax      <= 1'b0;
      rsp_priv_act <= 1'b0;
      fsr_we       <= 1'b0;
      fsr_reason   <= '0;
      fsr_ctx      <= '0;
      fsr_side_eff <= 1'b0;
      fsr_offset   <= '0;
      fsr_write    <= 1'b0;
    end else begin
      rsp_valid    <= vin;
      rsp_allow    <= vin && (vd == VD_ALLOW);
      rsp_dax      <= vin && (vd == VD_DAX);
      rsp_priv_act <= vin && (vd == VD_PACT);
      fsr_we       <= fault;
      fsr_reason   <= fault ? REASON_ILLEGAL_ID : 3'b000;
      fsr_ctx      <= CTX_PRIMARY;
      fsr_side_eff <= fault;
      fsr_offset   <= fault ? off : '0;
      fsr_write    <= fault && wr;
    end
  end
endmodule

// File: rtl/preg_access_check.sv
module preg_access_check
  import pac_pkg::*;
#(
  parameter int          OFF_W     = 16,
  parameter logic [31:0] SCR_TOP   = 32'h38,
  parameter logic [31:0] SCR_HP_LO = 32'h20,
  parameter logic [31:0] SCR_HP_HI = 32'h2F,
  parameter logic [31:0] Q_LO      = 32'h3C0,
  parameter logic [31:0] Q_HI      = 32'h3F8,
  parameter int unsigned ALIGN_LOG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_space,
  input  logic [OFF_W-1:0] req_offset,
  input  logic             req_write,
  input  logic             mode_priv,
  input  logic             mode_hpriv,
  output logic             rsp_valid,
  output logic             rsp_allow,
  output logic             rsp_dax,
  output logic             rsp_priv_act,
  output logic             fsr_we,
  output logic [2:0]       fsr_reason,
  output logic [1:0]       fsr_ctx,
  output logic             fsr_side_eff,
  output logic [OFF_W-1:0] fsr_offset,
  output logic             fsr_write
);
  logic [31:0] off32;
  assign off32 = 32'(req_offset);

  // named per-rule events
  verdict_e vd_scr, vd_que, vd_err, vd_sel;
  logic scr_beyond, scr_hpwin;
  logic que_nomode, que_outside, que_misalign;

  pac_scratch_rule #(
    .SCR_TOP(SCR_TOP), .SCR_HP_LO(SCR_HP_LO), .SCR_HP_HI(SCR_HP_HI)
  ) u_scr (
    .off(off32), .hpriv(mode_hpriv), .vd(vd_scr),
    .beyond_top(scr_beyond), .hp_window(scr_hpwin)
  );

  pac_queue_rule #(
    .Q_LO(Q_LO), .Q_HI(Q_HI), .ALIGN_LOG(ALIGN_LOG)
  ) u_que (
    .off(off32), .priv(mode_priv), .hpriv(mode_hpriv), .vd(vd_que),
    .no_mode(que_nomode), .outside(que_outside), .misalign(que_misalign)
  );

  pac_error_rule u_err (
    .priv(mode_priv), .hpriv(mode_hpriv), .vd(vd_err)
  );

  always_comb begin
    unique case (space_e'(req_space))
      SP_SCRATCH: vd_sel = vd_scr;
      SP_QUEUE:   vd_sel = vd_que;
      SP_ERROR:   vd_sel = vd_err;
      default:    vd_sel = VD_DAX;
    endcase
  end

  pac_resp_reg #(.OFF_W(OFF_W)) u_resp (
    .clk(clk), .rst_n(rst_n), .vin(req_valid), .vd(vd_sel),
    .off(req_offset), .wr(req_write),
    .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_dax(rsp_dax),
    .rsp_priv_act(rsp_priv_act), .fsr_we(fsr_we), .fsr_reason(fsr_reason),
    .fsr_ctx(fsr_ctx), .fsr_side_eff(fsr_side_eff),
    .fsr_offset(fsr_offset), .fsr_write(fsr_write)
  );
endmodule

// File: rtl/pac_checker.sv
module pac_checker #(
  parameter int          OFF_W   = 16,
  parameter logic [31:0] SCR_TOP = 32'h38
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [1:0]       req_space,
  input logic [OFF_W-1:0] req_offset,
  input logic             mode_priv,
  input logic             mode_hpriv,
  input logic             rsp_valid,
  input logic             rsp_allow,
  input logic             rsp_dax,
  input logic             rsp_priv_act,
  input logic             fsr_we,
  input logic             fsr_side_eff,
  input logic [OFF_W-1:0] fsr_offset
);
  p_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_allow && !rsp_dax && !rsp_priv_act && !fsr_we));
  p_one_verdict_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_allow, rsp_dax, rsp_priv_act}) == 1);
  p_scratch_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_space == 2'b00 && 32'(req_offset) > SCR_TOP) |=> rsp_dax);
  p_queue_nomode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_space == 2'b01 && !mode_priv && !mode_hpriv) |=> rsp_priv_act);
  p_error_hpriv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_space == 2'b10 && mode_hpriv) |=> rsp_allow);
  p_unused_space_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_space == 2'b11) |=> rsp_dax);
  p_fault_logged_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_dax || rsp_priv_act) |-> (fsr_we && fsr_side_eff));
  p_allow_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_allow |-> !fsr_we);
  p_log_offset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_space == 2'b11) |=> fsr_offset == $past(req_offset));
endmodule

bind preg_access_check pac_checker #(.OFF_W(OFF_W), .SCR_TOP(SCR_TOP)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_space(req_space),
  .req_offset(req_offset), .mode_priv(mode_priv), .mode_hpriv(mode_hpriv),
  .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_dax(rsp_dax),
  .rsp_priv_act(rsp_priv_act), .fsr_we(fsr_we), .fsr_side_eff(fsr_side_eff),
  .fsr_offset(fsr_offset)
);

// File: tb/preg_access_check_test.sv
`timescale 1ns/1ps
module preg_access_check_test;
  localparam int OW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_space = 2'b00;
  logic [OW-1:0] req_offset = '0;
  logic req_write = 1'b0, mode_priv = 1'b0, mode_hpriv = 1'b0;
  logic rsp_valid, rsp_allow, rsp_dax, rsp_priv_act, fsr_we, fsr_side_eff, fsr_write;
  logic [2:0] fsr_reason;
  logic [1:0] fsr_ctx;
  logic [OW-1:0] fsr_offset;

  always #2.5 clk = ~clk;

  preg_access_check #(.OFF_W(OW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_space(req_space),
    .req_offset(req_offset), .req_write(req_write), .mode_priv(mode_priv),
    .mode_hpriv(mode_hpriv), .rsp_valid(rsp_valid), .rsp_allow(rsp_allow),
    .rsp_dax(rsp_dax), .rsp_priv_act(rsp_priv_act), .fsr_we(fsr_we),
    .fsr_reason(fsr_reason), .fsr_ctx(fsr_ctx), .fsr_side_eff(fsr_side_eff),
    .fsr_offset(fsr_offset), .fsr_write(fsr_write)
  );

  typedef struct {
    logic [2:0]    verdict;   // {allow, dax, pact}
    logic [OW-1:0] off;
    logic          wr;
    string         tag;
  } item_t;

  item_t exp_q[$];
  int total = 0;
  int bad = 0;
  bit mon_on = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // bench's own restatement of the rules; returns {allow,dax,pact}
  function automatic logic [2:0] rule(input logic [1:0] sp, input int off,
                                      input logic p, input logic h);
    if (sp == 2'b11) return 3'b010;
    if (sp == 2'b10) return h ? 3'b100 : (p ? 3'b010 : 3'b001);
    if (sp == 2'b01) begin
      if (!p && !h) return 3'b001;
      if (off < 'h3C0 || off > 'h3F8) return 3'b010;
      if (!h && (off % 16) != 0) return 3'b010;
      return 3'b100;
    end
    if (off > 'h38) return 3'b010;
    if (!h && off >= 'h20 && off < 'h30) return 3'b010;
    return 3'b100;
  endfunction

  task automatic issue(input logic [1:0] sp, input int off, input logic wr,
                       input logic p, input logic h, input string tag);
    item_t it;
    @(negedge clk);
    req_valid = 1'b1; req_space = sp; req_offset = OW'(off);
    req_write = wr; mode_priv = p; mode_hpriv = h;
    it.verdict = rule(sp, off, p, h);
    it.off = OW'(off); it.wr = wr; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // monitor / scoreboard
  initial begin
    item_t e;
    logic fault;
    wait (mon_on);
    forever begin
      @(posedge clk); #1;
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected response", 32'(rsp_valid), 32'h0);
        end else begin
          e = exp_q.pop_front();
          fault = e.verdict != 3'b100;
          chk({rsp_allow, rsp_dax, rsp_priv_act} == e.verdict, e.tag,
              32'({rsp_allow, rsp_dax, rsp_priv_act}), 32'(e.verdict));
          chk(fsr_we == fault && fsr_side_eff == fault &&
              fsr_reason == (fault ? 3'b101 : 3'b000) && fsr_ctx == 2'b00,
              {"R10 record flags ", e.tag},
              32'({fsr_we, fsr_side_eff, fsr_reason, fsr_ctx}),
              32'({fault, fault, fault ? 3'b101 : 3'b000, 2'b00}));
          chk(fsr_offset == (fault ? e.off : '0) && fsr_write == (fault && e.wr),
              {"R10 record data ", e.tag},
              32'({fsr_write, fsr_offset}), 32'({fault && e.wr, fault ? e.off : OW'(0)}));
        end
      end else begin
        chk(!rsp_allow && !rsp_dax && !rsp_priv_act && !fsr_we && fsr_offset == '0,
            "R2 idle outputs", 32'({rsp_allow, rsp_dax, rsp_priv_act, fsr_we}), 32'h0);
      end
    end
  end

  // watchdog
  initial begin
    #200us;
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1;
    chk({rsp_valid, rsp_allow, rsp_dax, rsp_priv_act, fsr_we} == 5'b0,
        "R1 outputs in reset", 32'({rsp_valid, rsp_allow, rsp_dax, rsp_priv_act, fsr_we}), 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk({rsp_valid, rsp_allow, rsp_dax, rsp_priv_act, fsr_we, fsr_offset} == '0,
        "R1 first cycle after reset", 32'({rsp_valid, fsr_we}), 32'h0);
    mon_on = 1;

    // scratch
    issue(2'b00, 'h00, 0, 0, 0, "R4 scratch 0x00 user");
    issue(2'b00, 'h18, 1, 0, 0, "R4 scratch 0x18 user");
    issue(2'b00, 'h38, 0, 1, 0, "R3 scratch 0x38 edge");
    issue(2'b00, 'h39, 1, 1, 1, "R3 scratch 0x39 hpriv");
    issue(2'b00, 'h40, 0, 0, 0, "R3 scratch 0x40");
    idle(2);
    issue(2'b00, 'h20, 1, 0, 0, "R4 scratch 0x20 user");
    issue(2'b00, 'h28, 0, 1, 0, "R4 scratch 0x28 priv");
    issue(2'b00, 'h2F, 0, 1, 0, "R4 scratch 0x2F priv");
    issue(2'b00, 'h20, 0, 0, 1, "R4 scratch 0x20 hpriv");
    issue(2'b00, 'h30, 1, 0, 0, "R4 scratch 0x30 user");
    issue(2'b00, 'h1F, 0, 0, 0, "R4 scratch 0x1F user");
    idle(1);
    // queue
    issue(2'b01, 'h3C0, 0, 0, 0, "R5 queue user in window");
    issue(2'b01, 'h000, 1, 0, 0, "R5 queue user out of window");
    issue(2'b01, 'h3C0, 0, 1, 0, "R6 queue priv 0x3C0");
    issue(2'b01, 'h3F0, 1, 1, 0, "R6 queue priv 0x3F0");
    issue(2'b01, 'h3B0, 0, 1, 0, "R6 queue priv 0x3B0");
    issue(2'b01, 'h3B8, 1, 0, 1, "R6 queue hpriv 0x3B8");
    issue(2'b01, 'h3F9, 0, 0, 1, "R6 queue hpriv 0x3F9");
    issue(2'b01, 'h400, 1, 1, 1, "R6 queue both 0x400");
    issue(2'b01, 'h3F8, 0, 1, 0, "R7 queue priv 0x3F8 misaligned");
    issue(2'b01, 'h3F8, 1, 0, 1, "R7 queue hpriv 0x3F8");
    issue(2'b01, 'h3C4, 1, 1, 0, "R7 queue priv 0x3C4");
    issue(2'b01, 'h3C4, 0, 0, 1, "R7 queue hpriv 0x3C4");
    idle(3);
    // error
    issue(2'b10, 'h00, 0, 0, 1, "R8 error hpriv");
    issue(2'b10, 'h08, 1, 1, 0, "R8 error priv");
    issue(2'b10, 'h10, 1, 0, 0, "R8 error user");
    issue(2'b10, 'h18, 0, 1, 1, "R8 error both");
    // unused code
    issue(2'b11, 'h05, 1, 1, 1, "R9 unused space hpriv");
    issue(2'b11, 'h3C0, 0, 0, 0, "R9 unused space user");
    idle(4);

    chk(exp_q.size() == 0, "R2 all responses seen", 32'(exp_q.size()), 32'h0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule